// File: doc/BRIEF.md
# Protected Processor Status Register

This block holds the 8-bit processor status word of a small microcontroller core. The low four bits are arithmetic flags. Software can load them through the data-memory write path, and the ALU updates them after each operation. Two further bits record system history: one marks that the core went through a halt, the other that the watchdog expired. Only power-up, watchdog events and the halt and watchdog-clear instructions can change these two bits. Software stores cannot reach them. The register sits at data-memory address 0x0A.

The core drives the ALU strobes with a per-flag mask, so an instruction that affects only some flags leaves the others alone. The status word is not saved automatically when an interrupt is taken or a subroutine is called. Firmware that needs it must copy it out, and its copy can restore only the arithmetic bits.

Top module: `status_flag_reg`

## Requirements
- R1: Bit map of `status_o`: carry at bit 0, half-carry at bit 1, zero at bit 2, overflow at bit 3, halt-seen at bit 4, watchdog-expired at bit 5. Bits 7:6 always read 0.
- R2: When `rst` is high at a rising clock edge, every bit of `status_o` is 0 after that edge.
- R3: A write with `wr_en` high and `wr_addr` equal to 0x0A loads `wr_data[3:0]` into bits 3:0 at the next edge. A write to any other address changes nothing.
- R4: A software write never changes bit 4 or bit 5, whatever `wr_data[5:4]` holds.
- R5: `wdt_clear` clears bit 4 and bit 5 at the next edge, unless another event in R6, R7 or R9 takes priority.
- R6: `halt_exec` sets bit 4 and clears bit 5 at the next edge.
- R7: `wdt_timeout` sets bit 5. It wins over `wdt_clear` and `halt_exec` in the same cycle.
- R8: For each flag i in 0..3, `alu_mask[i]` high loads `alu_val[i]` into bit i. This overrides a software write to the same bit in the same cycle. Bits whose mask bit is low still take a same-cycle software write.
- R9: When `halt_exec` and `wdt_clear` arrive together, bit 4 ends set.
- R10: With no write, no ALU mask bit and no system event, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| wr_en | input | 1 | Data-memory write strobe |
| wr_addr | input | 8 | Data-memory write address |
| wr_data | input | 8 | Data-memory write value |
| alu_mask | input | 4 | Per-flag ALU update enables |
| alu_val | input | 4 | ALU flag results |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| wdt_clear | input | 1 | Watchdog-clear instruction strobe |
| halt_exec | input | 1 | Halt instruction strobe |
| status_o | output | 8 | Register value |

## Verification
The hardest states to reach are the ones where several sources act on the same bit in one cycle. Examples are a software write colliding with a partial ALU mask, or a timeout coinciding with halt or watchdog-clear. Ordinary traffic never produces these. The stimulus therefore first sets both system bits through their own events. It then drives the colliding strobes in a single cycle, and writes words with bits 5:4 set to show that those bits cannot be reached by software.

// File: rtl/status_pkg.sv
package status_pkg;

    localparam int unsigned ARITH_FLAGS = 4;
    localparam int unsigned STATUS_W    = 8;

    localparam int unsigned POS_C   = 0;
    localparam int unsigned POS_AC  = 1;
    localparam int unsigned POS_Z   = 2;
    localparam int unsigned POS_OV  = 3;
    localparam int unsigned POS_HLT = 4;
    localparam int unsigned POS_WTO = 5;

    typedef logic [ARITH_FLAGS-1:0] arith_t;

    typedef struct packed {
        logic wto;  // watchdog expired
        logic hlt;  // halt seen
    } sys_flags_t;

    typedef struct packed {
        logic timeout;
        logic clear;
        logic halt;
    } sys_evt_t;

    function automatic logic [STATUS_W-1:0] compose(input arith_t a, input sys_flags_t s);
        logic [STATUS_W-1:0] w;
        w           = '0;
        w[POS_OV:POS_C] = a;
        w[POS_HLT]  = s.hlt;
        w[POS_WTO]  = s.wto;
        return w;
    endfunction

endpackage

// File: rtl/arith_flag_bank.sv
module arith_flag_bank
    import status_pkg::*;
#(
    parameter int unsigned NFLAGS = ARITH_FLAGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_wr,
    input  logic [NFLAGS-1:0] sw_val,
    input  logic [NFLAGS-1:0] alu_mask,
    input  logic [NFLAGS-1:0] alu_val,
    output logic [NFLAGS-1:0] flags_o
);

    genvar i;
    generate
        for (i = 0; i < NFLAGS; i++) begin : g_flag
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (alu_mask[i])
                    bit_q <= alu_val[i];
                else if (sw_wr)
                    bit_q <= sw_val[i];
            end
            assign flags_o[i] = bit_q;

            assert_alu_wins_R8: assert property (@(posedge clk) disable iff (rst)
                alu_mask[i] |=> (flags_o[i] == $past(alu_val[i])));

            assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
                (!alu_mask[i] && !sw_wr) |=> $stable(flags_o[i]));
        end
    endgenerate

endmodule

// File: rtl/sys_flag_bank.sv
module sys_flag_bank
    import status_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sys_evt_t   evt,
    output sys_flags_t flags_o
);

    sys_flags_t q, d;

    always_comb begin
        d = q;
        // halt-seen: halt sets, clear resets; halt dominates
        if (evt.halt)
            d.hlt = 1'b1;
        else if (evt.clear)
            d.hlt = 1'b0;
        // watchdog-expired: timeout dominates both clearing sources
        if (evt.timeout)
            d.wto = 1'b1;
        else if (evt.clear || evt.halt)
            d.wto = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

    assign flags_o = q;

    assert_timeout_sets_R7: assert property (@(posedge clk) disable iff (rst)
        evt.timeout |=> flags_o.wto);

    assert_halt_marks_R6: assert property (@(posedge clk) disable iff (rst)
        evt.halt |=> flags_o.hlt);

    assert_halt_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (evt.halt && evt.clear) |=> flags_o.hlt);

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (evt.clear && !evt.halt && !evt.timeout) |=> (!flags_o.hlt && !flags_o.wto));

endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import status_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = STATUS_W,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0A
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ARITH_FLAGS-1:0] alu_mask,
    input  logic [ARITH_FLAGS-1:0] alu_val,
    input  logic                   wdt_timeout,
    input  logic                   wdt_clear,
    input  logic                   halt_exec,
    output logic [STATUS_W-1:0]    status_o
);

    logic       sel_wr;
    arith_t     arith_q;
    sys_flags_t sys_q;
    sys_evt_t   evt;

    assign sel_wr = wr_en && (wr_addr == REG_ADDR);

    assign evt.timeout = wdt_timeout;
    assign evt.clear   = wdt_clear;
    assign evt.halt    = halt_exec;

    arith_flag_bank #(.NFLAGS(ARITH_FLAGS)) u_arith (
        .clk      (clk),
        .rst      (rst),
        .sw_wr    (sel_wr),
        .sw_val   (wr_data[ARITH_FLAGS-1:0]),
        .alu_mask (alu_mask),
        .alu_val  (alu_val),
        .flags_o  (arith_q)
    );

    sys_flag_bank u_sys (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .flags_o (sys_q)
    );

    assign status_o = compose(arith_q, sys_q);

    assert_spare_zero_R1: assert property (@(posedge clk) disable iff (rst)
        status_o[STATUS_W-1:POS_WTO+1] == '0);

    assert_sw_blocked_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wdt_timeout && !wdt_clear && !halt_exec)
            |=> $stable(status_o[POS_WTO:POS_HLT]));

    assert_foreign_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (!sel_wr && alu_mask == '0 && !wdt_timeout && !wdt_clear && !halt_exec)
            |=> $stable(status_o));

endmodule

// File: tb/status_flag_reg_tb.sv
module status_flag_reg_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] alu_mask = 4'h0;
    logic [3:0] alu_val = 4'h0;
    logic       wdt_timeout = 1'b0;
    logic       wdt_clear = 1'b0;
    logic       halt_exec = 1'b0;
    logic [7:0] status_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    // reference state built from the requirements
    logic [3:0] m_ar = 4'h0;
    logic       m_hlt = 1'b0;
    logic       m_wto = 1'b0;

    always #4 clk = ~clk;

    status_flag_reg u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alu_mask(alu_mask), .alu_val(alu_val), .wdt_timeout(wdt_timeout),
        .wdt_clear(wdt_clear), .halt_exec(halt_exec), .status_o(status_o)
    );

    task automatic step(input string tag, input logic r, input logic we, input logic [7:0] ad,
                        input logic [7:0] dt, input logic [3:0] mk, input logic [3:0] av,
                        input logic tmo, input logic clr, input logic hlt);
        @(negedge clk);
        rst = r; wr_en = we; wr_addr = ad; wr_data = dt;
        alu_mask = mk; alu_val = av; wdt_timeout = tmo; wdt_clear = clr; halt_exec = hlt;
        if (r) begin
            m_ar = 4'h0; m_hlt = 1'b0; m_wto = 1'b0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (mk[i]) m_ar[i] = av[i];
                else if (we && ad == 8'h0A) m_ar[i] = dt[i];
            end
            if (hlt) m_hlt = 1'b1;
            else if (clr) m_hlt = 1'b0;
            if (tmo) m_wto = 1'b1;
            else if (clr || hlt) m_wto = 1'b0;
        end
        exp_q.push_back({2'b00, m_wto, m_hlt, m_ar});
        tag_q.push_back(tag);
    endtask

    // monitor: compares each registered result two ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (status_o !== e) begin
                    errors++;
                    $display("FAIL %s actual=%02h expected=%02h", t, status_o, e);
                end
            end
        end
    end

    initial begin
        step("R2 reset", 1, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 0, 0);
        step("R2 reset hold", 1, 1, 8'h0A, 8'hFF, 4'hF, 4'hF, 1, 0, 1);
        step("R2 reset clears", 1, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 0, 0);
        step("R3 write", 0, 1, 8'h0A, 8'h05, 4'h0, 4'h0, 0, 0, 0);
        step("R3 write other addr", 0, 1, 8'h0B, 8'h0A, 4'h0, 4'h0, 0, 0, 0);
        step("R3 write no enable", 0, 0, 8'h0A, 8'h0F, 4'h0, 4'h0, 0, 0, 0);
        step("R1 R4 write upper bits", 0, 1, 8'h0A, 8'hFA, 4'h0, 4'h0, 0, 0, 0);
        step("R6 halt", 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 0, 1);
        step("R7 timeout", 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 1, 0, 0);
        step("R4 write zeros keeps sys", 0, 1, 8'h0A, 8'h00, 4'h0, 4'h0, 0, 0, 0);
        step("R10 idle hold", 0, 0, 8'h3C, 8'hFF, 4'h0, 4'h0, 0, 0, 0);
        step("R5 clear", 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 1, 0);
        step("R7 timeout", 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 1, 0, 0);
        step("R6 halt clears wto", 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 0, 1);
        step("R7 timeout beats clear", 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 1, 1, 0);
        step("R7 timeout beats halt", 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 1, 0, 1);
        step("R9 halt with clear", 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 1, 1);
        step("R5 clear alone", 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 1, 0);
        step("R8 alu full", 0, 0, 8'h00, 8'h00, 4'hF, 4'h9, 0, 0, 0);
        step("R8 alu over write", 0, 1, 8'h0A, 8'h06, 4'h5, 4'h0, 0, 0, 0);
        step("R8 alu over write b", 0, 1, 8'h0A, 8'h00, 4'hA, 4'hA, 0, 0, 0);
        step("R8 alu partial", 0, 0, 8'h00, 8'h00, 4'h4, 4'h0, 0, 0, 0);
        step("R1 all set", 0, 1, 8'h0A, 8'hFF, 4'h0, 4'h0, 1, 0, 1);
        step("R10 idle final", 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 0, 0);
        step("R2 reset mid run", 1, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 0, 0);
        step("R10 idle after reset", 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 0, 0);
        wait (exp_q.size() == 0);
        @(posedge clk);
        #3;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule